// File: doc/BRIEF.md
# Amplitude Ramp Controller

This block produces the 10-bit amplitude scale word of one synthesizer output channel. A single control input picks the direction. While it is high, the scale word climbs toward a programmed target. While it is low, the scale word falls toward zero. The word moves in steps of 1, 2, 4 or 8 LSB, and each step lasts a programmable number of clock periods. A limit flag shows when the word has arrived at the end it is heading for.

A step that would pass its end point stops exactly on that point. An I/O update strobe can restart the step timer, so that step timing lines up with register updates. When the ramp function is switched off, the block reports the unity scale word, so the channel output is not attenuated.

Top module: `amp_ramp_ctrl`

## Requirements
- R1: While `rst` is high, the internal level goes to 0 and the step timer is cleared. The first enabled clock edge after reset therefore applies a step at once.
- R2: When `ramp_en` is low, `scale_out` is 1023 (unity), `at_limit` is 0, and the level and the timer are cleared.
- R3: `step_sel` sets the step size: 00 is 1 LSB, 01 is 2 LSB, 10 is 4 LSB, 11 is 8 LSB. No single clock changes `scale_out` by more than 8 while the block is enabled.
- R4: Every step after the first lasts `ramp_rate` clock periods. A `ramp_rate` of 0 behaves as 1.
- R5: With `ramp_up` high, the level rises toward `target_asf`. A step that would exceed the target lands exactly on it.
- R6: With `ramp_up` low, the level falls toward 0. A step that would go below 0 lands exactly on 0.
- R7: `at_limit` is high when the block is enabled and the level equals its goal (the target when rising, 0 when falling). While it is high, the level and the timer hold.
- R8: An `io_update` pulse while `load_on_update` is high reloads the timer. The next step then follows `ramp_rate` periods later. This reload takes precedence over a step that is due in the same cycle.
- R9: An `io_update` pulse while `load_on_update` is low has no effect on step timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (sync-clock domain) |
| rst | input | 1 | Synchronous active-high reset |
| target_asf | input | 10 | Programmed amplitude target |
| ramp_rate | input | 8 | Periods per step |
| step_sel | input | 2 | Step size select |
| ramp_en | input | 1 | Ramp function enable |
| ramp_up | input | 1 | Direction control: 1 rises, 0 falls |
| load_on_update | input | 1 | Lets `io_update` reload the timer |
| io_update | input | 1 | I/O update strobe |
| scale_out | output | 10 | Current amplitude scale word |
| at_limit | output | 1 | Level has reached its goal |

## Verification
Several properties hold only when the control fields stay steady around a step. The overshoot check and the limit-hold check assume the target and the direction stay fixed across the cycle they observe, and they give up the claim whenever those inputs move. The step-gap check assumes the rate was at least 2 on the edge that loaded the timer. The stimulus changes the fields only on falling edges, and it changes them between phases rather than in the middle of a ramp, except for the deliberate direction flip and the strobe pulses, where the guards apply.

// File: rtl/amp_ramp_pkg.sv
package amp_ramp_pkg;

    localparam int ASF_W   = 10;
    localparam int SEL_W   = 2;
    localparam logic [ASF_W-1:0] ASF_UNITY = '1;

    typedef enum logic [SEL_W-1:0] {
        STEP_1LSB = 2'b00,
        STEP_2LSB = 2'b01,
        STEP_4LSB = 2'b10,
        STEP_8LSB = 2'b11
    } step_sel_e;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'b00,
        DIR_RISE = 2'b01,
        DIR_FALL = 2'b10
    } ramp_dir_e;

    typedef struct packed {
        logic [ASF_W-1:0] next_level;
        ramp_dir_e        dir;
    } step_res_t;

    function automatic logic [ASF_W-1:0] step_amount(input step_sel_e sel);
        return ASF_W'(1) << sel;
    endfunction

endpackage

// File: rtl/amp_rate_timer.sv
module amp_rate_timer #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              run,
    input  logic              reload_req,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [RATE_W-1:0] cnt_q;
    logic [RATE_W-1:0] reload_val;

    // A rate of 0 is treated as 1, so the reload value never wraps.
    assign reload_val = (rate == '0) ? '0 : rate - RATE_W'(1);
    assign tick       = run && !reload_req && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (reload_req) begin
            cnt_q <= reload_val;
        end else if (run) begin
            if (cnt_q == '0) begin
                cnt_q <= reload_val;
            end else begin
                cnt_q <= cnt_q - RATE_W'(1);
            end
        end
    end
endmodule

// File: rtl/amp_step_unit.sv
module amp_step_unit
    import amp_ramp_pkg::*;
(
    input  logic [ASF_W-1:0] level,
    input  logic [ASF_W-1:0] goal,
    input  step_sel_e        sel,
    output step_res_t        res
);
    logic [ASF_W-1:0] amt;
    logic [ASF_W-1:0] gap;

    assign amt = step_amount(sel);

    always_comb begin
        res.next_level = level;
        res.dir        = DIR_HOLD;
        gap            = '0;
        if (level < goal) begin
            gap            = goal - level;
            res.dir        = DIR_RISE;
            res.next_level = (gap <= amt) ? goal : level + amt;
        end else if (level > goal) begin
            gap            = level - goal;
            res.dir        = DIR_FALL;
            res.next_level = (gap <= amt) ? goal : level - amt;
        end
    end
endmodule

// File: rtl/amp_ramp_ctrl.sv
module amp_ramp_ctrl
    import amp_ramp_pkg::*;
#(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ASF_W-1:0]  target_asf,
    input  logic [RATE_W-1:0] ramp_rate,
    input  logic [SEL_W-1:0]  step_sel,
    input  logic              ramp_en,
    input  logic              ramp_up,
    input  logic              load_on_update,
    input  logic              io_update,
    output logic [ASF_W-1:0]  scale_out,
    output logic              at_limit
);
    logic [ASF_W-1:0] level_q;
    logic [ASF_W-1:0] goal;
    logic             at_goal;
    logic             tick;
    step_res_t        step_res;

    assign goal    = ramp_up ? target_asf : '0;
    assign at_goal = (level_q == goal);

    amp_rate_timer #(.RATE_W(RATE_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .clear      (!ramp_en),
        .run        (ramp_en && !at_goal),
        .reload_req (ramp_en && load_on_update && io_update),
        .rate       (ramp_rate),
        .tick       (tick)
    );

    amp_step_unit u_step (
        .level (level_q),
        .goal  (goal),
        .sel   (step_sel_e'(step_sel)),
        .res   (step_res)
    );

    always_ff @(posedge clk) begin
        if (rst || !ramp_en) begin
            level_q <= '0;
        end else if (tick) begin
            level_q <= step_res.next_level;
        end
    end

    assign scale_out = ramp_en ? level_q : ASF_UNITY;
    assign at_limit  = ramp_en && at_goal;
endmodule

// File: rtl/amp_ramp_chk.sv
module amp_ramp_chk #(
    parameter int RATE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [9:0]        target_asf,
    input logic [RATE_W-1:0] ramp_rate,
    input logic              ramp_en,
    input logic              ramp_up,
    input logic [9:0]        scale_out,
    input logic              at_limit
);
    AST_OFF_UNITY: assert property (@(posedge clk) disable iff (rst)
        !ramp_en |-> (scale_out == 10'h3FF && !at_limit)); // R2

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (ramp_en && $past(ramp_en)) |->
        (((scale_out > $past(scale_out)) ? (scale_out - $past(scale_out))
                                         : ($past(scale_out) - scale_out)) <= 10'd8)); // R3

    AST_STEP_GAP: assert property (@(posedge clk) disable iff (rst)
        (ramp_en && $past(ramp_en) && !$stable(scale_out) && $past(ramp_rate) >= 2)
        |=> (!ramp_en || $stable(scale_out))); // R4

    AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (rst)
        (ramp_en && ramp_up && scale_out <= target_asf)
        |=> (!ramp_en || !ramp_up || !$stable(target_asf) || scale_out <= target_asf)); // R5

    AST_FALL_MONO: assert property (@(posedge clk) disable iff (rst)
        (ramp_en && !ramp_up)
        |=> (!ramp_en || ramp_up || scale_out <= $past(scale_out))); // R6

    AST_LIMIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ramp_en && at_limit)
        |=> (!ramp_en || !$stable(ramp_up) || !$stable(target_asf) || $stable(scale_out))); // R7
endmodule

bind amp_ramp_ctrl amp_ramp_chk #(.RATE_W(RATE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .target_asf (target_asf),
    .ramp_rate  (ramp_rate),
    .ramp_en    (ramp_en),
    .ramp_up    (ramp_up),
    .scale_out  (scale_out),
    .at_limit   (at_limit)
);

// File: tb/amp_ramp_ctrl_tb.sv
module amp_ramp_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] target_asf = '0;
    logic [7:0] ramp_rate = '0;
    logic [1:0] step_sel = '0;
    logic       ramp_en = 1'b0;
    logic       ramp_up = 1'b0;
    logic       load_on_update = 1'b0;
    logic       io_update = 1'b0;
    logic [9:0] scale_out;
    logic       at_limit;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amp_ramp_ctrl u_dut (
        .clk(clk), .rst(rst), .target_asf(target_asf), .ramp_rate(ramp_rate),
        .step_sel(step_sel), .ramp_en(ramp_en), .ramp_up(ramp_up),
        .load_on_update(load_on_update), .io_update(io_update),
        .scale_out(scale_out), .at_limit(at_limit)
    );

    typedef struct packed {
        logic [9:0] tgt;
        logic [7:0] rate;
        logic [1:0] sel;
        logic [8:0] edges;
        logic [9:0] exp_val;
        logic       exp_flag;
    } vec_t;

    // Rising ramps from reset: level after e edges = min(tgt, (1 + (e-1)/rate) * step)
    localparam vec_t VECS [8] = '{
        '{10'd100,  8'd4,   2'd0, 9'd9,   10'd3,   1'b0},  // R3 R4 R5
        '{10'd100,  8'd1,   2'd3, 9'd5,   10'd40,  1'b0},  // R3
        '{10'd20,   8'd1,   2'd3, 9'd5,   10'd20,  1'b1},  // R5 clamp
        '{10'd1023, 8'd2,   2'd2, 9'd7,   10'd16,  1'b0},  // R3 R4
        '{10'd50,   8'd3,   2'd1, 9'd10,  10'd8,   1'b0},  // R3 R4
        '{10'd0,    8'd5,   2'd0, 9'd6,   10'd0,   1'b1},  // R7
        '{10'd100,  8'd0,   2'd0, 9'd6,   10'd6,   1'b0},  // R4 rate 0
        '{10'd1023, 8'd255, 2'd3, 9'd256, 10'd16,  1'b0}   // R4 max rate
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ramp_en = 1'b0; ramp_up = 1'b0;
        io_update = 1'b0; load_on_update = 1'b0;
        edges(1);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        edges(2);
        // R1: reset holds level at zero even with the ramp enabled
        ramp_en = 1'b1; ramp_up = 1'b1; target_asf = 10'd100; ramp_rate = 8'd4;
        edges(2);
        check("R1 reset level", scale_out, 0);
        rst = 1'b0;
        edges(1);
        check("R1 first step immediate", scale_out, 1);

        // R2: disabled gives unity and no flag
        ramp_en = 1'b0;
        edges(3);
        check("R2 disabled unity", scale_out, 1023);
        check("R2 disabled flag", at_limit, 0);

        for (int i = 0; i < 8; i++) begin
            do_reset();
            target_asf = VECS[i].tgt; ramp_rate = VECS[i].rate;
            step_sel = VECS[i].sel; ramp_up = 1'b1; ramp_en = 1'b1;
            edges(int'(VECS[i].edges));
            check($sformatf("R3/R4/R5 vector %0d scale", i), scale_out, int'(VECS[i].exp_val));
            check($sformatf("R7 vector %0d flag", i), at_limit, int'(VECS[i].exp_flag));
        end

        // R6: fall toward zero with clamp
        do_reset();
        target_asf = 10'd16; ramp_rate = 8'd1; step_sel = 2'd3; ramp_up = 1'b1; ramp_en = 1'b1;
        edges(2);
        check("R5 reach 16", scale_out, 16);
        check("R7 flag at target", at_limit, 1);
        ramp_up = 1'b0; step_sel = 2'd0;
        edges(3);
        check("R6 fall 1 LSB", scale_out, 13);
        step_sel = 2'd3;
        edges(2);
        check("R6 clamp at zero", scale_out, 0);
        check("R7 flag at zero", at_limit, 1);
        edges(5);
        check("R7 hold at zero", scale_out, 0);

        // R8: update strobe with load enabled restarts the timer
        do_reset();
        target_asf = 10'd100; ramp_rate = 8'd4; step_sel = 2'd0; ramp_up = 1'b1; ramp_en = 1'b1;
        edges(3);
        load_on_update = 1'b1; io_update = 1'b1;
        edges(1);
        io_update = 1'b0;
        edges(3);
        check("R8 step delayed by reload", scale_out, 1);
        edges(1);
        check("R8 step after reload", scale_out, 2);

        // R9: strobe ignored without load enabled
        do_reset();
        target_asf = 10'd100; ramp_rate = 8'd4; step_sel = 2'd0; ramp_up = 1'b1; ramp_en = 1'b1;
        edges(3);
        load_on_update = 1'b0; io_update = 1'b1;
        edges(1);
        io_update = 1'b0;
        edges(3);
        check("R9 strobe ignored", scale_out, 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule